// File: doc/BRIEF.md
# Ring-Oscillator Phase Transition Counter

This block is the digital back end of an oscillator-based quantizer. A ring of delay cells inside a voltage-controlled oscillator presents one bit for each cell. On every sampling edge the block captures those bits and keeps the sample taken one period earlier. Each cell's two samples are compared with an exclusive-OR. A 1 marks a cell that switched during the last period. A balanced adder tree adds up the marks, and the sum is registered as the output code. A faster oscillator moves its transition further around the ring in one period, so the code tracks the oscillator frequency.

The registered per-cell marks are also brought out as a vector of unit-element controls, one bit for each feedback DAC element. Because the set of active cells moves around the ring from period to period, the elements are used in rotation without any extra logic. With no input the oscillator runs at half of its top rate, so the code sits near mid-scale.

A parameter can place a two-flop synchronizer in front of the capture register. This adds exactly two cycles to both the data and the valid flag. When it is left out, one capture stage and one output register separate the taps from the code.

Top module: `ringTapCounter`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `codeOut`, `toggleFlags` and `codeValid` to zero, along with every sample and synchronizer register.
- R2: With the synchronizer left out, `codeValid` first reads 1 after the third rising edge that follows reset release. It then stays at 1 until the next reset.
- R3: When `codeValid` is 1, bit i of `toggleFlags` is the XOR of tap i as captured at the two edges before the last one. With the synchronizer enabled, those are the captures two edges earlier still.
- R4: `codeOut` equals the number of ones in `toggleFlags`. Its full range of 0 to 31 is representable, so all 31 cells switching reads back as 31.
- R5: When the ring moves its transition forward by k cells every period (0 ≤ k ≤ 31), `codeOut` settles to exactly k every cycle. This includes 0, full scale, and a move that crosses the ring's wrap point.
- R6: With `SYNC_EN` = 1, `codeValid` first reads 1 after the fifth edge after reset release. The data has the same two extra cycles of delay.
- R7: While `codeValid` is 0, `codeOut` and `toggleFlags` read zero.
- R8: When the advance changes from one period to the next, each output code reflects the advance of the single period that the two captured samples span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Active-high synchronous reset |
| ringTaps | input | NUM_TAPS (31) | Present state of every delay cell |
| codeOut | output | CNT_W (5) | Registered count of cells that switched |
| toggleFlags | output | NUM_TAPS (31) | Registered per-cell switch marks, used as unit-element DAC controls |
| codeValid | output | 1 | Output code and flags are valid |

## Verification
The bench drives a behavioural ring whose transition advances by a programmed number of cells each period. It covers advances of zero and of full scale, where a wrong adder width would read 31 as a small number, and advances across the wrap point, where a misindexed cell would drop one count. It changes the advance every period to catch a design whose latency is off by one: the codes would appear shifted against the stimulus. It also counts the edges until valid, both with and without the synchronizer, to catch a capture stage that is missing or doubled. A reset in the middle of a run shows whether stale previous samples leak into the first code after the restart.

// File: rtl/ringTapCounterPkg.sv
package ringTapCounterPkg;
  typedef struct packed {
    logic pairReady;
  } ctrlStrobes_t;
endpackage

// File: rtl/ringTapCounterCtrl.sv
module ringTapCounterCtrl
  import ringTapCounterPkg::*;
#(
  parameter int FILL_EDGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  output ctrlStrobes_t strobes,
  output logic         codeValid
);
  localparam int FILL_W = $clog2(FILL_EDGES + 1);
  localparam logic [FILL_W-1:0] FILL_LIMIT = FILL_W'(FILL_EDGES);

  logic [FILL_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt   <= '0;
      codeValid <= 1'b0;
    end else begin
      if (fillCnt != FILL_LIMIT) fillCnt <= fillCnt + 1'b1;
      codeValid <= strobes.pairReady;
    end
  end

  always_comb strobes.pairReady = (fillCnt == FILL_LIMIT);
endmodule

// File: rtl/ringTapCounterPath.sv
module ringTapCounterPath
  import ringTapCounterPkg::*;
#(
  parameter int NUM_TAPS    = 31,
  parameter int SYNC_DEPTH  = 0,
  parameter int CNT_W       = $clog2(NUM_TAPS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [NUM_TAPS-1:0] ringTaps,
  output logic [CNT_W-1:0]    codeOut,
  output logic [NUM_TAPS-1:0] toggleFlags
);
  localparam int TREE_LVL = $clog2(NUM_TAPS);
  localparam int LEAVES   = 1 << TREE_LVL;
  localparam int NODES    = 2 * LEAVES - 1;

  logic [NUM_TAPS-1:0] syncedTaps;
  logic [NUM_TAPS-1:0] currSample;
  logic [NUM_TAPS-1:0] prevSample;
  logic [NUM_TAPS-1:0] flipBits;
  logic [CNT_W-1:0]    treeNode [NODES];

  generate
    if (SYNC_DEPTH > 0) begin : g_sync
      logic [NUM_TAPS-1:0] syncStage [SYNC_DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < SYNC_DEPTH; s++) syncStage[s] <= '0;
        end else begin
          syncStage[0] <= ringTaps;
          for (int s = 1; s < SYNC_DEPTH; s++) syncStage[s] <= syncStage[s-1];
        end
      end
      assign syncedTaps = syncStage[SYNC_DEPTH-1];
    end else begin : g_nosync
      assign syncedTaps = ringTaps;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      currSample <= '0;
      prevSample <= '0;
    end else begin
      currSample <= syncedTaps;
      prevSample <= currSample;
    end
  end

  assign flipBits = currSample ^ prevSample;

  // Heap-ordered balanced adder tree: node k sums nodes 2k+1 and 2k+2.
  generate
    for (genvar leaf = 0; leaf < LEAVES; leaf++) begin : g_leaf
      if (leaf < NUM_TAPS) begin : g_used
        assign treeNode[LEAVES-1+leaf] = CNT_W'(flipBits[leaf]);
      end else begin : g_pad
        assign treeNode[LEAVES-1+leaf] = '0;
      end
    end
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_add
      assign treeNode[k] = treeNode[2*k+1] + treeNode[2*k+2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      codeOut     <= '0;
      toggleFlags <= '0;
    end else if (strobes.pairReady) begin
      codeOut     <= treeNode[0];
      toggleFlags <= flipBits;
    end
  end
endmodule

// File: rtl/ringTapCounter.sv
module ringTapCounter
  import ringTapCounterPkg::*;
#(
  parameter int NUM_TAPS = 31,
  parameter bit SYNC_EN  = 1'b0,
  parameter int CNT_W    = $clog2(NUM_TAPS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAPS-1:0] ringTaps,
  output logic [CNT_W-1:0]    codeOut,
  output logic [NUM_TAPS-1:0] toggleFlags,
  output logic                codeValid
);
  localparam int SYNC_DEPTH = SYNC_EN ? 2 : 0;
  localparam int FILL_EDGES = 2 + SYNC_DEPTH;

  ctrlStrobes_t strobes;

  ringTapCounterCtrl #(.FILL_EDGES(FILL_EDGES)) i_ctrl (
    .clk(clk), .rst(rst), .strobes(strobes), .codeValid(codeValid)
  );

  ringTapCounterPath #(.NUM_TAPS(NUM_TAPS), .SYNC_DEPTH(SYNC_DEPTH), .CNT_W(CNT_W)) i_path (
    .clk(clk), .rst(rst), .strobes(strobes), .ringTaps(ringTaps),
    .codeOut(codeOut), .toggleFlags(toggleFlags)
  );
endmodule

// File: rtl/ringTapCounterChecker.sv
module ringTapCounterChecker #(
  parameter int NUM_TAPS = 31,
  parameter bit SYNC_EN  = 1'b0,
  parameter int CNT_W    = $clog2(NUM_TAPS + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_TAPS-1:0] ringTaps,
  input logic [CNT_W-1:0]    codeOut,
  input logic [NUM_TAPS-1:0] toggleFlags,
  input logic                codeValid
);
  localparam int D = SYNC_EN ? 2 : 0;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!codeValid && codeOut == '0 && toggleFlags == '0));

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    codeValid |=> codeValid);

  assert_flags_match_taps_R3: assert property (@(posedge clk) disable iff (rst)
    codeValid |-> (toggleFlags == ($past(ringTaps, 2 + D) ^ $past(ringTaps, 3 + D))));

  assert_code_counts_flags_R4: assert property (@(posedge clk) disable iff (rst)
    codeOut == CNT_W'($countones(toggleFlags)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    int'(codeOut) <= NUM_TAPS);

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !codeValid |-> (codeOut == '0 && toggleFlags == '0));
endmodule

bind ringTapCounter ringTapCounterChecker #(
  .NUM_TAPS(NUM_TAPS), .SYNC_EN(SYNC_EN), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst(rst), .ringTaps(ringTaps), .codeOut(codeOut),
  .toggleFlags(toggleFlags), .codeValid(codeValid)
);

// File: tb/test_ringTapCounter.sv
`timescale 1ns/1ps
module test_ringTapCounter;
  localparam int N   = 31;
  localparam int CW  = 5;
  localparam int PER = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  ringTaps = '0;
  logic [CW-1:0] codeOut, codeOutS;
  logic [N-1:0]  toggleFlags, toggleFlagsS;
  logic          codeValid, codeValidS;

  int checks = 0;
  int errors = 0;
  int phase = 0;
  int edgeCnt = 0;
  logic [N-1:0] hist [8];

  always #(PER/2) clk = ~clk;

  ringTapCounter #(.NUM_TAPS(N), .SYNC_EN(1'b0)) i_ringTapCounter (
    .clk(clk), .rst(rst), .ringTaps(ringTaps), .codeOut(codeOut),
    .toggleFlags(toggleFlags), .codeValid(codeValid));

  ringTapCounter #(.NUM_TAPS(N), .SYNC_EN(1'b1)) i_ringTapCounterSync (
    .clk(clk), .rst(rst), .ringTaps(ringTaps), .codeOut(codeOutS),
    .toggleFlags(toggleFlagsS), .codeValid(codeValidS));

  function automatic logic [N-1:0] ringPattern(int p);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (p < N) ? (i < p) : !(i < p - N);
    return v;
  endfunction

  function automatic int popCount(logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(string tag, string what, longint actual, longint expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, actual, expected);
    end
  endtask

  // Compare both instances with the model history after an edge.
  task automatic checkBoth(string tag);
    logic [N-1:0] expF;
    logic expV;
    expV = (edgeCnt >= 3);
    expF = expV ? (hist[1] ^ hist[2]) : '0;
    check(tag, "valid", codeValid, expV);
    check(tag, "flags", toggleFlags, expF);
    check(tag, "code", codeOut, popCount(expF));
    expV = (edgeCnt >= 5);
    expF = expV ? (hist[3] ^ hist[4]) : '0;
    check("R6", "sync valid", codeValidS, expV);
    check("R6", "sync flags", toggleFlagsS, expF);
    check("R6", "sync code", codeOutS, popCount(expF));
  endtask

  // Drive the ring forward by adv cells, clock once, sample at falling edge.
  task automatic step(int adv, string tag);
    phase = (phase + adv) % (2 * N);
    ringTaps = ringPattern(phase);
    @(posedge clk);
    #1;
    if (rst) begin
      edgeCnt = 0;
      for (int j = 0; j < 8; j++) hist[j] = '0;
    end else begin
      edgeCnt++;
      for (int j = 7; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = ringTaps;
    end
    @(negedge clk);
    checkBoth(tag);
  endtask

  task automatic doReset();
    rst = 1'b1;
    step(3, "R1");
    step(5, "R1");
    check("R1", "code in reset", codeOut, 0);
    check("R1", "flags in reset", toggleFlags, 0);
    check("R1", "valid in reset", codeValid, 0);
    rst = 1'b0;
  endtask

  task automatic testValidTiming();
    doReset();
    step(7, "R7"); check("R2", "valid edge1", codeValid, 0);
    step(7, "R7"); check("R2", "valid edge2", codeValid, 0);
    step(7, "R2"); check("R2", "valid edge3", codeValid, 1);
    check("R2", "first code", codeOut, 7);
    step(7, "R6"); check("R6", "sync valid edge4", codeValidS, 0);
    step(7, "R6"); check("R6", "sync valid edge5", codeValidS, 1);
    check("R6", "sync first code", codeOutS, 7);
  endtask

  task automatic testConstant(int k, int cycles);
    for (int c = 0; c < cycles; c++) step(k, "R3");
    for (int c = 0; c < 4; c++) begin
      step(k, "R5");
      check("R5", "constant advance code", codeOut, k);
      check("R4", "flag ones", popCount(toggleFlags), k);
      check("R5", "sync constant code", codeOutS, k);
    end
  endtask

  task automatic testVarying();
    int seq [8] = '{3, 29, 0, 31, 16, 1, 22, 9};
    for (int c = 0; c < 6; c++) step(4, "R8");
    for (int c = 0; c < 8; c++) begin
      step(seq[c], "R8");
      if (c >= 1) check("R8", "varying code", codeOut, seq[c-1]);
    end
  endtask

  task automatic testMidReset();
    for (int c = 0; c < 5; c++) step(20, "R5");
    doReset();
    step(2, "R7"); check("R7", "code after restart", codeOut, 0);
    step(2, "R7");
    step(2, "R1"); check("R1", "first code after restart", codeOut, 2);
  endtask

  initial begin
    for (int j = 0; j < 8; j++) hist[j] = '0;
    @(negedge clk);
    testValidTiming();
    testConstant(15, 6);
    testConstant(16, 4);
    testConstant(0, 4);
    testConstant(31, 4);
    testConstant(1, 70);
    testConstant(13, 12);
    testVarying();
    testMidReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PER * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule